// File: doc/BRIEF.md
# Dual-Organization Bit SRAM

This block is a synthesizable model of a static memory whose normal data path is one bit wide. It has three active-low controls: chip select, write strobe and output enable. A width pin switches the same storage between two views. With the pin low, every address selects a single bit. With the pin high, every address selects a group of four neighbouring bits, so a memory test can cover the array in a quarter of the accesses. The control combination decodes into four modes: deselected, write, read and output disabled.

A write happens while write strobe and chip select are both low. It is committed when that overlap ends, whichever of the two strobes rises first. The committed value is the address and data seen on the last sample taken inside the overlap. All inputs are sampled on the system clock `clk`. The data output `qData` comes with a registered drive enable `qOe`, which the chip level uses to control its tristate pad. When the output is not driven, `qData` is forced to zero. The storage is split into a row field, taken from the upper linear-address bits, and a column field, taken from the lower bits. A four-bit group always lies within one row.

Top module: `dual_org_sram`

## Requirements
- R1: While `csN` is high, no location is written, even if `weN` is low, and `qOe` is 0.
- R2: With `csN` and `weN` both low, the block is in the write mode, and `qOe` is 0 whatever the level of `oeN`.
- R3: A write commits on the first sample where the overlap of low `weN` and low `csN` is no longer seen, whether `weN` or `csN` rose. It stores the address, data and width taken on the last overlapping sample. A read sampled on that same cycle already returns the new value.
- R4: With `csN` low, `weN` high and `oeN` low, `qOe` is 1 and `qData` carries the addressed contents. Pins present at rising edge e show on the outputs after rising edge e+1.
- R5: With `csN` low, `weN` high and `oeN` high, `qOe` is 0 and nothing is written.
- R6: With `wideMode` low, all ADDR_W address bits select one bit. The write uses `dIn[0]`, the read value appears on `qData[0]`, and `qData[3:1]` is 0.
- R7: With `wideMode` high, bits `addr[ADDR_W-3:0]` select a group and the top two address bits are ignored. Lane k of `dIn` and `qData` is the single-bit location whose linear address is {addr[ADDR_W-3:0], k} with k in two bits.
- R8: Whenever `qOe` is 0, `qData` is all zero.
- R9: While `rstN` is low, `qOe` and `qData` are 0, and no write is pending after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address (the top two bits are ignored in the four-bit view) |
| csN | input | 1 | Active-low chip select |
| weN | input | 1 | Active-low write strobe |
| oeN | input | 1 | Active-low output enable |
| wideMode | input | 1 | 0: one bit per word, 1: four bits per word |
| dIn | input | 4 | Write data (only lane 0 is used in the one-bit view) |
| qData | output | 4 | Read data, zero when not driven |
| qOe | output | 1 | Registered drive enable for the output pad |

## Verification
The assertions assume that `rstN` is released away from a rising clock edge and that every control pin is settled at each rising edge. Given that, the pins seen at edge e decide the outputs seen two edges later. The bench changes all inputs on falling edges only, so each rising edge sees one stable control combination. The random stretch also moves the address and width in the middle of a write overlap, because the block defines which sample it commits.

// File: rtl/sram_pkg.sv
package sram_pkg;

  typedef enum logic [1:0] {
    MODE_DESEL  = 2'd0,
    MODE_WRITE  = 2'd1,
    MODE_READ   = 2'd2,
    MODE_OUTOFF = 2'd3
  } sramMode_e;

  typedef struct packed {
    logic capture;
    logic commit;
    logic readEn;
    logic wide;
  } dpStrobes_t;

endpackage

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       weN,
  input  logic       oeN,
  input  logic       wideMode,
  output dpStrobes_t strobes
);

  logic selS, wrS, oeActS, wideS;
  logic overlapPrev;
  logic overlapNow;
  sramMode_e mode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selS        <= 1'b0;
      wrS         <= 1'b0;
      oeActS      <= 1'b0;
      wideS       <= 1'b0;
      overlapPrev <= 1'b0;
    end else begin
      selS        <= ~csN;
      wrS         <= ~weN;
      oeActS      <= ~oeN;
      wideS       <= wideMode;
      overlapPrev <= overlapNow;
    end
  end

  always_comb begin
    if (!selS)       mode = MODE_DESEL;
    else if (wrS)    mode = MODE_WRITE;
    else if (oeActS) mode = MODE_READ;
    else             mode = MODE_OUTOFF;
  end

  assign overlapNow = (mode == MODE_WRITE);

  always_comb begin
    strobes.capture = overlapNow;
    strobes.commit  = overlapPrev & ~overlapNow;
    strobes.readEn  = (mode == MODE_READ);
    strobes.wide    = wideS;
  end

endmodule

// File: rtl/sram_datapath.sv
module sram_datapath
  import sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int ROW_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        dIn,
  input  dpStrobes_t        strobes,
  output logic [3:0]        qData,
  output logic              qOe
);

  localparam int COL_W = ADDR_W - ROW_W;
  localparam int ROWS  = 1 << ROW_W;
  localparam int COLS  = 1 << COL_W;

  logic [ADDR_W-1:0] addrS;
  logic [3:0]        dinS;
  logic [ADDR_W-1:0] holdLin;
  logic [3:0]        holdDin;
  logic              holdWide;
  logic [ADDR_W-1:0] baseLin;
  logic [3:0]        laneBit;

  logic [COLS-1:0] arr [ROWS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrS <= '0;
      dinS  <= '0;
    end else begin
      addrS <= addr;
      dinS  <= dIn;
    end
  end

  assign baseLin = strobes.wide ? {addrS[ADDR_W-3:0], 2'b00} : addrS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdLin  <= '0;
      holdDin  <= '0;
      holdWide <= 1'b0;
    end else if (strobes.capture) begin
      holdLin  <= baseLin;
      holdDin  <= dinS;
      holdWide <= strobes.wide;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.commit) begin
      if (holdWide) begin
        for (int k = 0; k < 4; k++) begin
          arr[holdLin[ADDR_W-1:COL_W]][{holdLin[COL_W-1:2], 2'(k)}] <= holdDin[k];
        end
      end else begin
        arr[holdLin[ADDR_W-1:COL_W]][holdLin[COL_W-1:0]] <= holdDin[0];
      end
    end
  end

  for (genvar g = 0; g < 4; g++) begin : gLane
    logic [ADDR_W-1:0] laneLin;
    logic              storedBit;
    logic              hit;
    logic              fwdBit;

    assign laneLin   = strobes.wide ? {addrS[ADDR_W-3:0], 2'(g)} : addrS;
    assign storedBit = arr[laneLin[ADDR_W-1:COL_W]][laneLin[COL_W-1:0]];
    assign hit       = strobes.commit &&
                       (holdWide ? (laneLin[ADDR_W-1:2] == holdLin[ADDR_W-1:2])
                                 : (laneLin == holdLin));
    assign fwdBit    = holdWide ? holdDin[laneLin[1:0]] : holdDin[0];
    assign laneBit[g] = hit ? fwdBit : storedBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qOe   <= 1'b0;
      qData <= '0;
    end else begin
      qOe <= strobes.readEn;
      if (!strobes.readEn)   qData <= '0;
      else if (strobes.wide) qData <= laneBit;
      else                   qData <= {3'b000, laneBit[0]};
    end
  end

endmodule

// File: rtl/dual_org_sram.sv
module dual_org_sram
  import sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int ROW_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              csN,
  input  logic              weN,
  input  logic              oeN,
  input  logic              wideMode,
  input  logic [3:0]        dIn,
  output logic [3:0]        qData,
  output logic              qOe
);

  dpStrobes_t strobes;

  sram_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .csN      (csN),
    .weN      (weN),
    .oeN      (oeN),
    .wideMode (wideMode),
    .strobes  (strobes)
  );

  sram_datapath #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .addr    (addr),
    .dIn     (dIn),
    .strobes (strobes),
    .qData   (qData),
    .qOe     (qOe)
  );

endmodule

// File: rtl/sram_checker.sv
module sram_checker (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic       weN,
  input logic       oeN,
  input logic       wideMode,
  input logic [3:0] qData,
  input logic       qOe
);

  assert_desel_off_R1: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> ##1 !qOe);

  assert_write_off_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !weN) |=> ##1 !qOe);

  assert_read_on_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && weN && !oeN) |=> ##1 qOe);

  assert_oe_off_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && weN && oeN) |=> ##1 !qOe);

  assert_narrow_lanes_R6: assert property (@(posedge clk) disable iff (!rstN)
    !wideMode |=> ##1 (qData[3:1] == 3'b000));

  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    !qOe |-> (qData == 4'b0000));

  always @(posedge clk) begin
    if (!rstN) begin
      assert_reset_quiet_R9: assert (!qOe && qData == 4'b0000);
    end
  end

endmodule

bind dual_org_sram sram_checker chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .csN      (csN),
  .weN      (weN),
  .oeN      (oeN),
  .wideMode (wideMode),
  .qData    (qData),
  .qOe      (qOe)
);

// File: tb/dual_org_sram_tb.sv
module dual_org_sram_tb_top;

  localparam int ADDR_W = 10;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int GROUPS = DEPTH / 4;

  typedef struct {
    bit       cs;
    bit       we;
    bit       oe;
    bit       wide;
    int       a;
    bit [3:0] d;
  } pinRec_t;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              csN = 1'b1;
  logic              weN = 1'b1;
  logic              oeN = 1'b1;
  logic              wideMode = 1'b0;
  logic [3:0]        dIn = '0;
  logic [3:0]        qData;
  logic              qOe;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  string phaseTag = "R9";

  bit       modelMem [DEPTH];
  pinRec_t  hist[$];
  bit       expOe = 1'b0;
  bit [3:0] expData = 4'b0;

  always #10 clk = ~clk;

  dual_org_sram #(.ADDR_W(ADDR_W), .ROW_W(4)) dut_i (
    .clk(clk), .rstN(rstN), .addr(addr), .csN(csN), .weN(weN), .oeN(oeN),
    .wideMode(wideMode), .dIn(dIn), .qData(qData), .qOe(qOe)
  );

  function automatic int linOf(int a, bit wide, int k);
    return wide ? ((a % GROUPS) * 4 + k) : a;
  endfunction

  function automatic bit isOverlap(pinRec_t r);
    return !r.cs && !r.we;
  endfunction

  // behavioural reference: pins seen at edge e decide outputs after edge e+1
  always @(posedge clk) begin
    pinRec_t cur, prev, nowRec;
    if (!rstN) begin
      hist.delete();
      expOe = 1'b0;
      expData = 4'b0;
    end else begin
      cur = '{cs: 1, we: 1, oe: 1, wide: 0, a: 0, d: 0};
      prev = cur;
      if (hist.size() >= 1) cur = hist[hist.size()-1];
      if (hist.size() >= 2) prev = hist[hist.size()-2];
      if (isOverlap(prev) && !isOverlap(cur)) begin
        if (prev.wide) for (int k = 0; k < 4; k++) modelMem[linOf(prev.a, 1, k)] = prev.d[k];
        else modelMem[prev.a] = prev.d[0];
      end
      expOe = !cur.cs && cur.we && !cur.oe;
      expData = 4'b0;
      if (expOe) begin
        if (cur.wide) for (int k = 0; k < 4; k++) expData[k] = modelMem[linOf(cur.a, 1, k)];
        else expData[0] = modelMem[cur.a];
      end
      nowRec = '{cs: csN, we: weN, oe: oeN, wide: wideMode, a: int'(addr), d: dIn};
      hist.push_back(nowRec);
      if (hist.size() > 2) void'(hist.pop_front());
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (!rstN) begin
      checks++;
      if (qOe !== 1'b0 || qData !== 4'b0) begin
        failures++;
        $display("FAIL R9 reset outputs: qOe=%b qData=%b expected 0/0000", qOe, qData);
      end
    end else begin
      checks++;
      if (qOe !== expOe) begin
        failures++;
        $display("FAIL %s qOe: actual=%b expected=%b at cycle %0d", phaseTag, qOe, expOe, cycles);
      end
      checks++;
      if (qData !== expData) begin
        failures++;
        $display("FAIL %s qData: actual=%b expected=%b at cycle %0d", phaseTag, qData, expData, cycles);
      end
    end
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected under 100000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic step(bit c, bit w, bit o, bit wd, int a, bit [3:0] d);
    @(negedge clk);
    csN = c; weN = w; oeN = o; wideMode = wd;
    addr = ADDR_W'(a); dIn = d;
  endtask

  task automatic idle();
    step(1, 1, 1, 0, 0, 4'h0);
  endtask

  task automatic wr(bit wd, int a, bit [3:0] d);
    step(0, 0, 1, wd, a, d);
    idle();
  endtask

  task automatic rd(bit wd, int a);
    step(0, 1, 0, wd, a, 4'h0);
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle();

    phaseTag = "R7";
    for (int i = 0; i < GROUPS; i++) wr(1, i, 4'((i * 7) ^ (i >> 2)));
    for (int i = 0; i < 16; i++) rd(0, i * 37 % DEPTH);

    phaseTag = "R6";
    wr(0, 36, 4'h0); wr(0, 37, 4'hF); wr(0, 38, 4'h0); wr(0, 39, 4'hF);
    rd(1, 9); rd(0, 37); rd(0, 38);

    phaseTag = "R7";
    wr(1, 5, 4'b0110);
    for (int k = 20; k < 24; k++) rd(0, k);
    wr(1, (3 << (ADDR_W - 2)) | 17, 4'b1001);
    rd(1, 17); rd(1, (2 << (ADDR_W - 2)) | 17); rd(0, 68); rd(0, 71);

    phaseTag = "R3";
    step(0, 0, 1, 0, 100, 4'h1); step(0, 0, 1, 0, 100, 4'h1);
    step(0, 1, 0, 0, 100, 4'h0); idle();
    step(0, 0, 1, 0, 101, 4'h0); step(0, 0, 1, 0, 101, 4'h1);
    step(0, 1, 0, 0, 101, 4'h0); idle();
    step(0, 0, 1, 1, 50, 4'hC); step(1, 0, 1, 1, 50, 4'h3); idle();
    rd(1, 50);

    phaseTag = "R1";
    step(1, 0, 0, 0, 60, 4'h1); step(1, 0, 0, 0, 61, 4'h0); idle();
    rd(0, 60); rd(0, 61);

    phaseTag = "R2";
    step(0, 0, 0, 0, 62, 4'h1); step(0, 0, 0, 0, 62, 4'h1); idle(); rd(0, 62);

    phaseTag = "R5";
    step(0, 1, 1, 0, 62, 4'h0); step(0, 1, 1, 1, 15, 4'h0); idle(); rd(1, 15);

    phaseTag = "R8";
    step(1, 1, 0, 1, 15, 4'h0); idle();

    phaseTag = "R4";
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 4) == 0, ($urandom % 3) != 0, $urandom % 2, $urandom % 2,
           $urandom % DEPTH, 4'($urandom));
    end
    idle(); idle();

    phaseTag = "R9";
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    rd(0, 100); idle(); idle();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule